// File: doc/BRIEF.md
# Atomic Wide-Register Byte Stager

This block presents one 24-bit configuration value to a byte-wide host bus as three adjacent byte addresses. Host writes go first into a staging buffer. The value reaches the active output only when all three bytes have been written in ascending order with no other bus operation in between. Hardware that consumes the value therefore never sees a half-written word.

Reads also run as a low-to-high sequence. Reading the low byte captures the whole active value in a read shadow. The two higher bytes are then served from that shadow, so the host assembles a coherent word even if a commit lands partway through its reads.

Write protection is handled outside the block and arrives as a single write-enable input. A sticky error flag records any write sequence that was broken.

Top module: `wide_reg_stager`

## Requirements
- R1: While reset is held, and right after it, `value_q` is zero, and `value_upd`, `seq_err` and `bus_rdata` are all zero.
- R2: The byte lanes are fixed. Address 0x04 holds bits 7:0, 0x05 holds bits 15:8 and 0x06 holds bits 23:16. An allowed write sequence 0x04, 0x05, 0x06 loads all three bytes into `value_q`, visible from the clock edge that samples the 0x06 write.
- R3: `value_q` holds its old contents during the first two writes of a sequence. It never shows a partly updated word.
- R4: `value_upd` is high for exactly the one cycle after the edge that loads `value_q`, and is low at all other times.
- R5: Idle cycles, meaning cycles with neither strobe, may sit between the writes of a sequence without breaking it.
- R6: An allowed write to 0x04 always starts a fresh sequence and discards any bytes already staged. It does not set `seq_err`.
- R7: While a sequence is open, any read, any allowed write outside the window, or any write to a byte other than the next one due ends the sequence. The staged bytes are discarded, `value_q` is left unchanged and `seq_err` is set. Later writes to 0x05 or 0x06 do not commit.
- R8: An allowed write to 0x05 or 0x06 while no sequence is open changes nothing except that it sets `seq_err`.
- R9: Once set, `seq_err` stays high until reset, including across later successful commits.
- R10: A write with `wr_allow` low has no effect. It does not stage, commit, open, break or flag a sequence.
- R11: A read drives `bus_rdata` one cycle later. A read of 0x04 returns bits 7:0 of `value_q` and copies the whole value into the shadow. Reads of 0x05 and 0x06 return shadow bytes 1 and 2, even if `value_q` has changed since the snapshot.
- R12: A read of any address outside 0x04 to 0x06 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the current bus operation |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | BYTE_W (8) | Write data byte |
| wr_allow | input | 1 | External write permission; a write with this low is ignored |
| bus_rdata | output | BYTE_W (8) | Read data, registered, valid the cycle after `bus_rd` |
| value_q | output | NUM_BYTES*BYTE_W (24) | Active configuration value |
| value_upd | output | 1 | One-cycle pulse after `value_q` is loaded |
| seq_err | output | 1 | Sticky flag for a broken write sequence |

## Verification
Every result of the block is one register stage from the bus strobe that causes it. `value_q` and `value_upd` change at the edge that samples the third write, `seq_err` at the edge that samples the offending operation, and `bus_rdata` at the edge that samples the read. The bench drives each operation for exactly one cycle, ending at that edge. It samples all outputs one nanosecond later, before the next operation starts, so each check sees only the effect of a single bus operation.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_OPEN = 1'b1
   } seq_state_e;
endpackage

// File: rtl/wrs_write_seq.sv
module wrs_write_seq
   import wrs_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 3,
   parameter int LANE_W    = 2,
   localparam int VAL_W    = NUM_BYTES * BYTE_W,
   localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_BYTES - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic              any_op,
   input  logic              in_win,
   input  logic [LANE_W-1:0] lane,
   input  logic [BYTE_W-1:0] wdata,
   output logic [VAL_W-1:0]  value,
   output logic              upd,
   output logic              err
);
   seq_state_e        state;
   logic [LANE_W-1:0] exp_lane;
   logic              wr_win, start, next_ok, last, break_seq, stray, accept;
   logic [VAL_W-1:0]  commit_val;
   logic [BYTE_W-1:0] stage [NUM_BYTES-1];

   assign wr_win    = wr_hit && in_win;
   assign start     = wr_win && (lane == '0);
   assign next_ok   = wr_win && (state == SEQ_OPEN) && (lane == exp_lane) && !start;
   assign last      = next_ok && (lane == LAST_LANE);
   assign accept    = start || next_ok;
   assign break_seq = (state == SEQ_OPEN) && any_op && !accept;
   assign stray     = wr_win && (state == SEQ_IDLE) && (lane != '0);

   // one staging byte per non-final lane, the final lane comes straight from the bus
   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
      if (g == NUM_BYTES - 1) begin : g_final
         assign commit_val[g*BYTE_W +: BYTE_W] = wdata;
      end else begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stage[g] <= '0;
            else if (accept && lane == LANE_W'(g))
               stage[g] <= wdata;
         end
         assign commit_val[g*BYTE_W +: BYTE_W] = stage[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         exp_lane <= '0;
         value    <= '0;
         upd      <= 1'b0;
         err      <= 1'b0;
      end else begin
         upd <= last;
         if (last)
            value <= commit_val;
         if (start) begin
            state    <= SEQ_OPEN;
            exp_lane <= LANE_W'(1);
         end else if (next_ok) begin
            if (last)
               state <= SEQ_IDLE;
            else
               exp_lane <= exp_lane + LANE_W'(1);
         end else if (break_seq) begin
            state <= SEQ_IDLE;
         end
         if (break_seq || stray)
            err <= 1'b1;
      end
   end
endmodule

// File: rtl/wrs_read_shadow.sv
module wrs_read_shadow #(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 3,
   parameter int LANE_W    = 2,
   localparam int VAL_W    = NUM_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              in_win,
   input  logic [LANE_W-1:0] lane,
   input  logic [VAL_W-1:0]  value,
   output logic [BYTE_W-1:0] rdata
);
   logic [VAL_W-1:0] shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         rdata  <= '0;
      end else if (rd) begin
         if (!in_win) begin
            rdata <= '0;
         end else if (lane == '0) begin
            shadow <= value;
            rdata  <= value[BYTE_W-1:0];
         end else begin
            rdata <= shadow[lane*BYTE_W +: BYTE_W];
         end
      end
   end
endmodule

// File: rtl/wide_reg_stager.sv
module wide_reg_stager #(
   parameter int ADDR_W    = 8,
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 3,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h04,
   localparam int LANE_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
   localparam int VAL_W  = NUM_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic              wr_allow,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic [VAL_W-1:0]  value_q,
   output logic              value_upd,
   output logic              seq_err
);
   if (NUM_BYTES < 2) begin : g_bad_count
      $error("wide_reg_stager: NUM_BYTES must be at least 2");
   end
   if (BYTE_W < 1) begin : g_bad_width
      $error("wide_reg_stager: BYTE_W must be positive");
   end
   if (int'(BASE_ADDR) + NUM_BYTES > (1 << ADDR_W)) begin : g_bad_base
      $error("wide_reg_stager: register window runs past the address space");
   end

   logic [ADDR_W-1:0] offs;
   logic              in_win, wr_hit, any_op;
   logic [LANE_W-1:0] lane;

   assign offs   = bus_addr - BASE_ADDR;
   assign in_win = (bus_addr >= BASE_ADDR) && (offs < ADDR_W'(NUM_BYTES));
   assign lane   = offs[LANE_W-1:0];
   assign wr_hit = bus_wr && wr_allow;
   assign any_op = wr_hit || bus_rd;

   wrs_write_seq #(
      .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .LANE_W(LANE_W)
   ) u_wseq (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .any_op(any_op),
      .in_win(in_win), .lane(lane), .wdata(bus_wdata),
      .value(value_q), .upd(value_upd), .err(seq_err)
   );

   wrs_read_shadow #(
      .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .LANE_W(LANE_W)
   ) u_rshadow (
      .clk(clk), .rst_n(rst_n), .rd(bus_rd), .in_win(in_win),
      .lane(lane), .value(value_q), .rdata(bus_rdata)
   );
endmodule

// File: rtl/wide_reg_stager_chk.sv
module wide_reg_stager_chk #(
   parameter int ADDR_W    = 8,
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 3,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h04,
   localparam int VAL_W = NUM_BYTES * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [BYTE_W-1:0] bus_wdata,
   input logic              wr_allow,
   input logic [BYTE_W-1:0] bus_rdata,
   input logic [VAL_W-1:0]  value_q,
   input logic              value_upd,
   input logic              seq_err
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = BASE_ADDR + ADDR_W'(NUM_BYTES - 1);
   logic outside;
   assign outside = (bus_addr < BASE_ADDR) || (bus_addr > TOP_ADDR);

   assert_upd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      value_upd |=> !value_upd);

   assert_no_silent_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(value_q) |-> value_upd);

   assert_commit_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && wr_allow && !bus_rd && bus_addr == TOP_ADDR) ##1 value_upd
      |-> value_q[VAL_W-1 -: BYTE_W] == $past(bus_wdata));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);

   assert_blocked_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !wr_allow && !bus_rd) |=> (!value_upd && $stable(value_q)));

   assert_outside_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && outside) |=> bus_rdata == '0);
endmodule

bind wide_reg_stager wide_reg_stager_chk #(
   .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .BASE_ADDR(BASE_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_wdata(bus_wdata), .wr_allow(wr_allow), .bus_rdata(bus_rdata),
   .value_q(value_q), .value_upd(value_upd), .seq_err(seq_err)
);

// File: tb/sim_wide_reg_stager.sv
`timescale 1ns/1ps
module sim_wide_reg_stager;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic        wr_allow = 1'b1;
   logic [7:0]  bus_rdata;
   logic [23:0] value_q;
   logic        value_upd;
   logic        seq_err;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wide_reg_stager u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .wr_allow(wr_allow), .bus_rdata(bus_rdata),
      .value_q(value_q), .value_upd(value_upd), .seq_err(seq_err)
   );

   // op: 0 idle, 1 write, 2 read | addr | data | value | upd | err | rdata
   localparam logic [51:0] VEC [0:21] = '{
      {2'd1, 8'h04, 8'h11, 24'h000000, 1'b0, 1'b0, 8'h00}, // R3 no partial
      {2'd1, 8'h05, 8'h22, 24'h000000, 1'b0, 1'b0, 8'h00}, // R3
      {2'd1, 8'h06, 8'h33, 24'h332211, 1'b1, 1'b0, 8'h00}, // R2 commit, R4
      {2'd0, 8'h00, 8'h00, 24'h332211, 1'b0, 1'b0, 8'h00}, // R4 pulse ends
      {2'd2, 8'h04, 8'h00, 24'h332211, 1'b0, 1'b0, 8'h11}, // R11
      {2'd2, 8'h05, 8'h00, 24'h332211, 1'b0, 1'b0, 8'h22}, // R11
      {2'd2, 8'h06, 8'h00, 24'h332211, 1'b0, 1'b0, 8'h33}, // R11
      {2'd1, 8'h04, 8'hAA, 24'h332211, 1'b0, 1'b0, 8'h00}, // R3
      {2'd0, 8'h00, 8'h00, 24'h332211, 1'b0, 1'b0, 8'h00}, // R5 idle gap
      {2'd1, 8'h05, 8'hBB, 24'h332211, 1'b0, 1'b0, 8'h00}, // R5
      {2'd1, 8'h06, 8'hCC, 24'hCCBBAA, 1'b1, 1'b0, 8'h00}, // R5 commit
      {2'd2, 8'h04, 8'h00, 24'hCCBBAA, 1'b0, 1'b0, 8'hAA}, // R11 snapshot
      {2'd1, 8'h04, 8'h01, 24'hCCBBAA, 1'b0, 1'b0, 8'h00}, // R6 no seq open
      {2'd1, 8'h05, 8'h02, 24'hCCBBAA, 1'b0, 1'b0, 8'h00},
      {2'd1, 8'h06, 8'h03, 24'h030201, 1'b1, 1'b0, 8'h00}, // R2
      {2'd2, 8'h05, 8'h00, 24'h030201, 1'b0, 1'b0, 8'hBB}, // R11 from shadow
      {2'd2, 8'h06, 8'h00, 24'h030201, 1'b0, 1'b0, 8'hCC}, // R11 from shadow
      {2'd2, 8'h08, 8'h00, 24'h030201, 1'b0, 1'b0, 8'h00}, // R12
      {2'd1, 8'h04, 8'h44, 24'h030201, 1'b0, 1'b0, 8'h00},
      {2'd1, 8'h04, 8'h55, 24'h030201, 1'b0, 1'b0, 8'h00}, // R6 restart, no error
      {2'd1, 8'h05, 8'h66, 24'h030201, 1'b0, 1'b0, 8'h00},
      {2'd1, 8'h06, 8'h77, 24'h776655, 1'b1, 1'b0, 8'h00}  // R6 restarted value
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus operation: driven after a falling edge, sampled 1 ns after the next rising edge
   task automatic step(input int op, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = (op == 1);
      bus_rd    = (op == 2);
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
      bus_rd = 1'b0;
   endtask

   task automatic expect_state(input string req, input logic [23:0] v, input logic u, input logic e);
      check({req, " value"}, 32'(value_q), 32'(v));
      check({req, " upd"}, 32'(value_upd), 32'(u));
      check({req, " err"}, 32'(seq_err), 32'(e));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      expect_state("R1 in reset", 24'h0, 1'b0, 1'b0);
      check("R1 rdata", 32'(bus_rdata), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      expect_state("R1 initial", 24'h0, 1'b0, 1'b0);
      check("R1 rdata", 32'(bus_rdata), 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < 22; i++) begin
         step(int'(VEC[i][51:50]), VEC[i][49:42], VEC[i][41:34]);
         expect_state($sformatf("R2/R3/R4 vec%0d", i), VEC[i][33:10], VEC[i][9], VEC[i][8]);
         if (VEC[i][51:50] == 2'd2)
            check($sformatf("R11/R12 vec%0d rdata", i), 32'(bus_rdata), 32'(VEC[i][7:0]));
      end

      // R10: blocked writes leave everything alone
      wr_allow = 1'b0;
      step(1, 8'h04, 8'h99); expect_state("R10 blocked", 24'h776655, 1'b0, 1'b0);
      step(1, 8'h05, 8'h98); expect_state("R10 blocked", 24'h776655, 1'b0, 1'b0);
      step(1, 8'h06, 8'h97); expect_state("R10 blocked", 24'h776655, 1'b0, 1'b0);
      wr_allow = 1'b1;
      step(1, 8'h04, 8'h01);
      step(1, 8'h05, 8'h02);
      step(1, 8'h06, 8'h03); expect_state("R10 later sequence", 24'h030201, 1'b1, 1'b0);

      // R7: read interrupts an open sequence
      step(1, 8'h04, 8'h10); expect_state("R7 open", 24'h030201, 1'b0, 1'b0);
      step(2, 8'h04, 8'h00); expect_state("R7 broken by read", 24'h030201, 1'b0, 1'b1);
      check("R11 rdata", 32'(bus_rdata), 32'h01);
      step(1, 8'h05, 8'h20); expect_state("R7 discarded", 24'h030201, 1'b0, 1'b1);
      step(1, 8'h06, 8'h30); expect_state("R7 no commit", 24'h030201, 1'b0, 1'b1);

      // R9: flag stays through a good commit
      step(1, 8'h04, 8'hA1);
      step(1, 8'h05, 8'hA2);
      step(1, 8'h06, 8'hA3); expect_state("R9 sticky", 24'hA3A2A1, 1'b1, 1'b1);

      // R7: skipped byte
      do_reset();
      step(1, 8'h04, 8'h55);
      step(1, 8'h06, 8'h66); expect_state("R7 skip", 24'h0, 1'b0, 1'b1);
      step(1, 8'h05, 8'h77);
      step(1, 8'h06, 8'h88); expect_state("R7 skip no commit", 24'h0, 1'b0, 1'b1);

      // R7: write to an address outside the window
      do_reset();
      step(1, 8'h04, 8'h01);
      step(1, 8'h05, 8'h02); expect_state("R7 pre", 24'h0, 1'b0, 1'b0);
      step(1, 8'h0A, 8'h03); expect_state("R7 foreign write", 24'h0, 1'b0, 1'b1);
      step(1, 8'h06, 8'h04); expect_state("R7 foreign no commit", 24'h0, 1'b0, 1'b1);

      // R8: stray upper-byte write with no open sequence
      do_reset();
      step(1, 8'h06, 8'h5A); expect_state("R8 stray", 24'h0, 1'b0, 1'b1);
      step(2, 8'h06, 8'h00);
      check("R8 shadow untouched", 32'(bus_rdata), 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule